// File: doc/BRIEF.md
# Predicated Execution Gate

This combinational unit decides whether an instruction whose execution depends on a condition may take effect. It takes the instruction's 4-bit condition selector and the four current status flags (negative, zero, carry, overflow) and produces one execute-enable bit. The rule applies to every instruction class. Arithmetic, logic, loads, stores and branches all pass through the same gate.

The unit also receives the three side-effect strobes of the instruction: the register-file write, the memory write and the status-flag update. It passes them on only when the condition holds. An instruction whose condition fails therefore leaves no architectural trace and acts as a no-op. The unit does not produce the flags, compute branch targets or flush the pipeline.

Top module: `cond_exec_unit`

## Requirements
- R1: Selector 0000 passes exactly when zero flag is 1; selector 0001 passes exactly when zero flag is 0.
- R2: Selector 0010 passes exactly when carry is 1; selector 0011 passes exactly when carry is 0.
- R3: Selector 0100 passes exactly when negative is 1; selector 0101 passes exactly when negative is 0.
- R4: Selector 0110 passes exactly when overflow is 1; selector 0111 passes exactly when overflow is 0.
- R5: Selector 1000 (unsigned higher) passes when carry is 1 and zero is 0; selector 1001 (unsigned lower-or-same) passes when carry is 0 or zero is 1.
- R6: Selector 1010 (signed greater-or-equal) passes when negative equals overflow; selector 1011 (signed less) passes when they differ.
- R7: Selector 1100 (signed greater) passes when zero is 0 and negative equals overflow; selector 1101 (signed less-or-equal) passes when zero is 1 or negative differs from overflow.
- R8: Selector 1110 passes for every flag combination.
- R9: Selector 1111 never passes, for any flag combination.
- R10: When the condition fails, the register-write, memory-write and flag-update outputs are all 0, whatever their inputs.
- R11: When the condition passes, each of the three strobe outputs equals its corresponding input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_sel | input | 4 | Condition selector field of the instruction |
| flag_n | input | 1 | Negative status flag |
| flag_z | input | 1 | Zero status flag |
| flag_c | input | 1 | Carry status flag |
| flag_v | input | 1 | Overflow status flag |
| rf_wr_in | input | 1 | Register-file write strobe from decode |
| mem_wr_in | input | 1 | Memory write strobe from decode |
| flg_upd_in | input | 1 | Flag-update strobe from decode |
| exec_ok | output | 1 | Condition holds; instruction may take effect |
| rf_wr_out | output | 1 | Gated register-file write strobe |
| mem_wr_out | output | 1 | Gated memory write strobe |
| flg_upd_out | output | 1 | Gated flag-update strobe |

## Verification
The embedded immediate assertions assume that every input is a known 0 or 1 when the combinational logic settles. An unknown selector or flag would make the per-selector checks meaningless. The bench drives only defined values. It first walks all 256 selector and flag pairings with randomised strobes, then applies a fixed-seed random mix, with directed corners for the always and never selectors. It changes inputs only at a clock edge and samples half a period later, so every assertion sees settled inputs.

// File: rtl/cond_exec_pkg.sv
package cond_exec_pkg;

    localparam int SEL_W   = 4;
    localparam int GROUP_W = SEL_W - 1;
    localparam int N_STB   = 3;

    typedef enum logic [SEL_W-1:0] {
        C_ZSET  = 4'b0000,
        C_ZCLR  = 4'b0001,
        C_CSET  = 4'b0010,
        C_CCLR  = 4'b0011,
        C_NSET  = 4'b0100,
        C_NCLR  = 4'b0101,
        C_VSET  = 4'b0110,
        C_VCLR  = 4'b0111,
        C_UHI   = 4'b1000,
        C_ULS   = 4'b1001,
        C_SGE   = 4'b1010,
        C_SLT   = 4'b1011,
        C_SGT   = 4'b1100,
        C_SLE   = 4'b1101,
        C_ALWAYS= 4'b1110,
        C_NEVER = 4'b1111
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic rf_wr;
        logic mem_wr;
        logic flg_upd;
    } strobes_t;

    // Positive sense of each selector pair; the selector LSB inverts it.
    function automatic logic group_truth(input logic [GROUP_W-1:0] grp,
                                         input flags_t f);
        logic sgn_ok;
        sgn_ok = ~(f.n ^ f.v);
        unique case (grp)
            3'd0: group_truth = f.z;
            3'd1: group_truth = f.c;
            3'd2: group_truth = f.n;
            3'd3: group_truth = f.v;
            3'd4: group_truth = f.c & ~f.z;
            3'd5: group_truth = sgn_ok;
            3'd6: group_truth = ~f.z & sgn_ok;
            default: group_truth = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import cond_exec_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  flags_t           flg,
    output logic             pass
);
    logic [GROUP_W-1:0] grp;
    logic               invert;
    logic               base;

    assign grp    = sel[SEL_W-1:1];
    assign invert = sel[0];

    always_comb begin
        base = group_truth(grp, flg);
        pass = base ^ invert;
    end

    always_comb begin
        if (cond_e'(sel) == C_ZSET)
            AST_ZERO_SET: assert (pass == flg.z) else $error("zero-set selector");   // R1
        if (cond_e'(sel) == C_CCLR)
            AST_CARRY_CLR: assert (pass == !flg.c) else $error("carry-clear selector"); // R2
        if (cond_e'(sel) == C_UHI)
            AST_UNS_HIGHER: assert (pass == (flg.c && !flg.z)) else $error("unsigned higher"); // R5
        if (cond_e'(sel) == C_SLT)
            AST_SIGNED_LESS: assert (pass == (flg.n != flg.v)) else $error("signed less"); // R6
        if (cond_e'(sel) == C_SLE)
            AST_SIGNED_LE: assert (pass == (flg.z || (flg.n != flg.v))) else $error("signed le"); // R7
        if (cond_e'(sel) == C_ALWAYS)
            AST_ALWAYS_PASS: assert (pass) else $error("always selector failed"); // R8
        if (cond_e'(sel) == C_NEVER)
            AST_NEVER_PASS: assert (!pass) else $error("never selector passed"); // R9
    end
endmodule

// File: rtl/strobe_gate.sv
module strobe_gate #(
    parameter int WIDTH = 3
) (
    input  logic             en,
    input  logic [WIDTH-1:0] stb_in,
    output logic [WIDTH-1:0] stb_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign stb_out[i] = stb_in[i] & en;
    end

    always_comb begin
        if (!en)
            AST_FAIL_SILENT: assert (stb_out == '0) else $error("strobe leaked"); // R10
        else
            AST_PASS_THROUGH: assert (stb_out == stb_in) else $error("strobe altered"); // R11
    end
endmodule

// File: rtl/cond_exec_unit.sv
module cond_exec_unit
    import cond_exec_pkg::*;
(
    input  logic [3:0] cond_sel,
    input  logic       flag_n,
    input  logic       flag_z,
    input  logic       flag_c,
    input  logic       flag_v,
    input  logic       rf_wr_in,
    input  logic       mem_wr_in,
    input  logic       flg_upd_in,
    output logic       exec_ok,
    output logic       rf_wr_out,
    output logic       mem_wr_out,
    output logic       flg_upd_out
);
    flags_t   flg;
    strobes_t stb_raw;
    strobes_t stb_gated;
    logic     pass;

    assign flg     = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};
    assign stb_raw = '{rf_wr: rf_wr_in, mem_wr: mem_wr_in, flg_upd: flg_upd_in};

    cond_eval u_eval (
        .sel  (cond_sel),
        .flg  (flg),
        .pass (pass)
    );

    strobe_gate #(.WIDTH(N_STB)) u_gate (
        .en      (pass),
        .stb_in  (stb_raw),
        .stb_out (stb_gated)
    );

    assign exec_ok     = pass;
    assign rf_wr_out   = stb_gated.rf_wr;
    assign mem_wr_out  = stb_gated.mem_wr;
    assign flg_upd_out = stb_gated.flg_upd;

    always_comb begin
        if (cond_sel == 4'b0101)
            AST_NEG_CLR: assert (exec_ok == !flag_n) else $error("neg-clear selector"); // R3
        if (cond_sel == 4'b0110)
            AST_OVF_SET: assert (exec_ok == flag_v) else $error("ovf-set selector");    // R4
    end
endmodule

// File: tb/tb_cond_exec_unit.sv
module tb_cond_exec_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [3:0] cond_sel;
    logic flag_n, flag_z, flag_c, flag_v;
    logic rf_wr_in, mem_wr_in, flg_upd_in;
    logic exec_ok, rf_wr_out, mem_wr_out, flg_upd_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    cond_exec_unit dut (
        .cond_sel(cond_sel), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
        .flag_v(flag_v), .rf_wr_in(rf_wr_in), .mem_wr_in(mem_wr_in),
        .flg_upd_in(flg_upd_in), .exec_ok(exec_ok), .rf_wr_out(rf_wr_out),
        .mem_wr_out(mem_wr_out), .flg_upd_out(flg_upd_out)
    );

    function automatic bit exp_pass(input logic [3:0] s, input logic [3:0] nzcv);
        bit n, z, c, v;
        {n, z, c, v} = nzcv;
        case (s)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c && !z;
            4'd9:  return !c || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] s);
        case (s[3:1])
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return s[0] ? "R9" : "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s sel=%b act=%b exp=%b", req, cond_sel, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] s, input logic [3:0] nzcv, input logic [2:0] st);
        bit p;
        @(posedge clk);
        cond_sel = s;
        {flag_n, flag_z, flag_c, flag_v} = nzcv;
        {rf_wr_in, mem_wr_in, flg_upd_in} = st;
        @(negedge clk);
        p = exp_pass(s, nzcv);
        check(req_of(s), {3'b000, exec_ok}, {3'b000, p});
        if (p) check("R11", {1'b0, rf_wr_out, mem_wr_out, flg_upd_out}, {1'b0, st});
        else   check("R10", {1'b0, rf_wr_out, mem_wr_out, flg_upd_out}, 4'b0000);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1A2B);
        cond_sel = 4'b1111; {flag_n, flag_z, flag_c, flag_v} = 4'b0000;
        {rf_wr_in, mem_wr_in, flg_upd_in} = 3'b111;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // reset-state check: never selector with all strobes high (R9, R10)
        @(negedge clk);
        check("R9", {3'b000, exec_ok}, 4'b0000);
        check("R10", {1'b0, rf_wr_out, mem_wr_out, flg_upd_out}, 4'b0000);
        // exhaustive walk over selectors and flags
        for (int s = 0; s < 16; s++)
            for (int f = 0; f < 16; f++)
                apply(4'(s), 4'(f), 3'($urandom));
        // directed corners: always/never with every strobe set
        for (int f = 0; f < 16; f++) begin
            apply(4'b1110, 4'(f), 3'b111);   // R8, R11
            apply(4'b1111, 4'(f), 3'b111);   // R9, R10
        end
        // random mix
        for (int k = 0; k < 400; k++)
            apply(4'($urandom), 4'($urandom), 3'($urandom));
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule